// File: doc/BRIEF.md
# Lookup CAM with LRU Replacement Hint

This block is a small private content-addressable memory for one processing engine. Firmware pairs it with a local data array to build a software-managed cache. Each entry holds a tag, a small state field and a valid bit. A lookup compares a key against every valid entry in one step. On a hit, the result names the matching entry and returns its state. On a miss, the result names the least-recently-used entry, so software knows which slot to refill next.

Software installs a line with a write command that gives the index, the tag and the state. The write also makes that entry the most recently used. A clear command empties the whole table and restarts the replacement order at entry 0. Only one command takes effect in a cycle. When several are raised together, clear wins over write, and write wins over lookup.

Top module: `lookup_cam`

## Requirements
- R1: The table has 16 entries, each with a 32-bit tag, a 4-bit state and a valid bit. A write stores the tag and state at `wr_idx_i` and marks that entry valid, so a later lookup of that tag hits.
- R2: An accepted lookup raises `res_valid_o` for exactly one cycle, in the cycle after the request. Without an accepted lookup, `res_valid_o` is low.
- R3: On a hit, `res_hit_o` is 1, `res_idx_o` is the matching entry and `res_state_o` is that entry's state.
- R4: When two or more valid entries hold the key, the lowest matching index is reported.
- R5: On a miss, `res_hit_o` is 0, `res_idx_o` is the least-recently-used entry and `res_state_o` is 0.
- R6: A lookup hit and a write each make the touched entry the most recently used. A lookup miss leaves the replacement order unchanged.
- R7: A clear invalidates every entry and resets the replacement order to 0, 1, ... 15, with entry 0 as the first victim.
- R8: An invalid entry never hits, whatever its stored tag is, including after reset.
- R9: Commands have a fixed priority: clear over write over lookup. A command raised in the same cycle as a higher-priority one is ignored.
- R10: After reset, `res_valid_o` is low, all entries are invalid and the replacement order is 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_key_i | input | 32 | Key to search for |
| wr_valid_i | input | 1 | Write request |
| wr_idx_i | input | 4 | Entry to write |
| wr_tag_i | input | 32 | Tag to store |
| wr_state_i | input | 4 | State to store |
| clr_i | input | 1 | Invalidate all entries |
| res_valid_o | output | 1 | Lookup result valid |
| res_hit_o | output | 1 | Lookup hit |
| res_idx_o | output | 4 | Hit index or victim index |
| res_state_o | output | 4 | State of the hit entry, 0 on a miss |

## Verification
The properties assume that the command inputs are known after reset, that they change only between clock edges, and that they are held low while reset is asserted. The bench drives every input on the falling edge and keeps all of them at zero during reset. Most cycles carry a single command. Commands are raised together only in the directed priority tests, where R9 defines the outcome.

// File: rtl/lcam_pkg.sv
package lcam_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_CLEAR  = 2'd1,
    CMD_WRITE  = 2'd2,
    CMD_LOOKUP = 2'd3
  } cam_cmd_e;
endpackage

// File: rtl/cam_match.sv
module cam_match #(
  parameter int N     = 16,
  parameter int TAG_W = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [TAG_W-1:0] tag_i [N],
  input  logic [N-1:0]     valid_i,
  input  logic [TAG_W-1:0] key_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tag_i[g] == key_i);
  end

  // descending scan: the lowest match is written last
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/cam_lru.sv
module cam_lru #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  // order_q[0] = least recent, order_q[N-1] = most recent
  logic [IDX_W-1:0] order_q [N];
  logic [IDX_W-1:0] order_d [N];
  logic [IDX_W-1:0] pos;

  always_comb begin
    pos = '0;
    for (int k = 0; k < N; k++) begin
      if (order_q[k] == touch_idx_i) pos = IDX_W'(k);
    end
  end

  for (genvar g = 0; g < N - 1; g++) begin : g_shift
    assign order_d[g] = (IDX_W'(g) >= pos) ? order_q[g+1] : order_q[g];
  end
  assign order_d[N-1] = touch_idx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N; k++) order_q[k] <= IDX_W'(k);
    end else if (clr_i) begin
      for (int k = 0; k < N; k++) order_q[k] <= IDX_W'(k);
    end else if (touch_i) begin
      for (int k = 0; k < N; k++) order_q[k] <= order_d[k];
    end
  end

  assign victim_o = order_q[0];
endmodule

// File: rtl/lookup_cam.sv
module lookup_cam
  import lcam_pkg::*;
#(
  parameter int N       = 16,
  parameter int TAG_W   = 32,
  parameter int STATE_W = 4,
  localparam int IDX_W  = $clog2(N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lkp_valid_i,
  input  logic [TAG_W-1:0]   lkp_key_i,
  input  logic               wr_valid_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  input  logic [STATE_W-1:0] wr_state_i,
  input  logic               clr_i,
  output logic               res_valid_o,
  output logic               res_hit_o,
  output logic [IDX_W-1:0]   res_idx_o,
  output logic [STATE_W-1:0] res_state_o
);
  logic [TAG_W-1:0]   tag_q   [N];
  logic [STATE_W-1:0] state_q [N];
  logic [N-1:0]       valid_q;

  cam_cmd_e         cmd;
  logic             m_hit;
  logic [IDX_W-1:0] m_idx;
  logic [IDX_W-1:0] victim;
  logic             touch;
  logic [IDX_W-1:0] touch_idx;

  always_comb begin
    if (clr_i)            cmd = CMD_CLEAR;
    else if (wr_valid_i)  cmd = CMD_WRITE;
    else if (lkp_valid_i) cmd = CMD_LOOKUP;
    else                  cmd = CMD_IDLE;
  end

  cam_match #(.N(N), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
    .tag_i   (tag_q),
    .valid_i (valid_q),
    .key_i   (lkp_key_i),
    .hit_o   (m_hit),
    .idx_o   (m_idx)
  );

  assign touch     = (cmd == CMD_WRITE) || ((cmd == CMD_LOOKUP) && m_hit);
  assign touch_idx = (cmd == CMD_WRITE) ? wr_idx_i : m_idx;

  cam_lru #(.N(N), .IDX_W(IDX_W)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (cmd == CMD_CLEAR),
    .touch_i     (touch),
    .touch_idx_i (touch_idx),
    .victim_o    (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int k = 0; k < N; k++) begin
        tag_q[k]   <= '0;
        state_q[k] <= '0;
      end
    end else if (cmd == CMD_CLEAR) begin
      valid_q <= '0;
    end else if (cmd == CMD_WRITE) begin
      valid_q[wr_idx_i] <= 1'b1;
      tag_q[wr_idx_i]   <= wr_tag_i;
      state_q[wr_idx_i] <= wr_state_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_hit_o   <= 1'b0;
      res_idx_o   <= '0;
      res_state_o <= '0;
    end else begin
      res_valid_o <= (cmd == CMD_LOOKUP);
      if (cmd == CMD_LOOKUP) begin
        res_hit_o   <= m_hit;
        res_idx_o   <= m_hit ? m_idx : victim;
        res_state_o <= m_hit ? state_q[m_idx] : '0;
      end
    end
  end
endmodule

// File: rtl/lookup_cam_chk.sv
module lookup_cam_chk #(
  parameter int N       = 16,
  parameter int TAG_W   = 32,
  parameter int STATE_W = 4,
  localparam int IDX_W  = $clog2(N)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lkp_valid_i,
  input logic [TAG_W-1:0]   lkp_key_i,
  input logic               wr_valid_i,
  input logic [IDX_W-1:0]   wr_idx_i,
  input logic [TAG_W-1:0]   wr_tag_i,
  input logic [STATE_W-1:0] wr_state_i,
  input logic               clr_i,
  input logic               res_valid_o,
  input logic               res_hit_o,
  input logic [IDX_W-1:0]   res_idx_o,
  input logic [STATE_W-1:0] res_state_o
);
  logic lkp_ok;
  logic wr_ok;
  assign lkp_ok = lkp_valid_i && !wr_valid_i && !clr_i;
  assign wr_ok  = wr_valid_i && !clr_i;

  p_res_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_ok |=> res_valid_o);

  p_no_res_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_ok |=> !res_valid_o);

  p_miss_state_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o) |-> (res_state_o == '0));

  p_clear_victim_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i ##1 lkp_ok) |=> (!res_hit_o && res_idx_o == '0));

  p_write_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok ##1 (lkp_ok && lkp_key_i == $past(wr_tag_i))) |=> res_hit_o);
endmodule

bind lookup_cam lookup_cam_chk #(.N(N), .TAG_W(TAG_W), .STATE_W(STATE_W)) u_chk (.*);

// File: tb/sim_lookup_cam.sv
`timescale 1ns/1ps
module sim_lookup_cam;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lkp_valid_i = 1'b0;
  logic [31:0] lkp_key_i = '0;
  logic        wr_valid_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [31:0] wr_tag_i = '0;
  logic [3:0]  wr_state_i = '0;
  logic        clr_i = 1'b0;
  logic        res_valid_o, res_hit_o;
  logic [3:0]  res_idx_o, res_state_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  lookup_cam u0 (.*);

  // op: 0 lookup, 1 write, 2 clear
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  idx;
    logic [31:0] tag;
    logic [3:0]  st;
    logic        eh;
    logic [3:0]  ei;
    logic [3:0]  es;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 4'd0, 32'h0,         4'd0,  1'b0, 4'd0, 4'd0},
    '{2'd0, 4'd0, 32'hDEAD_0000, 4'd0,  1'b0, 4'd0, 4'd0},
    '{2'd1, 4'd0, 32'h1000_0000, 4'd0,  1'b0, 4'd0, 4'd0},
    '{2'd1, 4'd1, 32'h1000_0001, 4'd1,  1'b0, 4'd0, 4'd0},
    '{2'd1, 4'd2, 32'h1000_0002, 4'd2,  1'b0, 4'd0, 4'd0},
    '{2'd1, 4'd3, 32'h1000_0003, 4'd3,  1'b0, 4'd0, 4'd0},
    '{2'd0, 4'd0, 32'h1000_0001, 4'd0,  1'b1, 4'd1, 4'd1},
    '{2'd0, 4'd0, 32'hDEAD_0000, 4'd0,  1'b0, 4'd4, 4'd0},
    '{2'd1, 4'd4, 32'h1000_0002, 4'd15, 1'b0, 4'd0, 4'd0},
    '{2'd0, 4'd0, 32'h1000_0002, 4'd0,  1'b1, 4'd2, 4'd2},
    '{2'd0, 4'd0, 32'hDEAD_0000, 4'd0,  1'b0, 4'd5, 4'd0}
  };

  task automatic idle_inputs();
    lkp_valid_i = 1'b0; wr_valid_i = 1'b0; clr_i = 1'b0;
  endtask

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] idx, input logic [31:0] tag, input logic [3:0] st);
    wr_valid_i = 1'b1; wr_idx_i = idx; wr_tag_i = tag; wr_state_i = st;
    @(negedge clk_i);
    idle_inputs();
  endtask

  task automatic do_clear();
    clr_i = 1'b1;
    @(negedge clk_i);
    idle_inputs();
  endtask

  // result fields packed as {valid, hit, idx, state}
  task automatic do_lookup(input logic [31:0] key, input logic eh, input logic [3:0] ei,
                           input logic [3:0] es, input string req);
    lkp_valid_i = 1'b1; lkp_key_i = key;
    @(negedge clk_i);
    idle_inputs();
    check(req, {res_valid_o, res_hit_o, res_idx_o, res_state_o}, {1'b1, eh, ei, es});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10: no result after reset
    check("R10 reset valid", {9'd0, res_valid_o}, 10'd0);
    // R8, R10: invalid entries with reset tag 0 never hit, entry 0 is victim
    do_lookup(32'h0, 1'b0, 4'd0, 4'd0, "R8 R10 reset miss");
    @(negedge clk_i);
    // R2: pulse lasts one cycle
    check("R2 one-cycle pulse", {9'd0, res_valid_o}, 10'd0);

    // table: R1 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      case (VECS[v].op)
        2'd0: do_lookup(VECS[v].tag, VECS[v].eh, VECS[v].ei, VECS[v].es, "R3 R4 R5 R6 table");
        2'd1: do_write(VECS[v].idx, VECS[v].tag, VECS[v].st);
        default: do_clear();
      endcase
    end

    // R6: fill entries 5..15; LRU order becomes 0,3,1,4,2,5..15
    for (int i = 5; i < 16; i++) do_write(4'(i), 32'h2000_0000 + 32'(i), 4'(i));
    do_lookup(32'h2000_000F, 1'b1, 4'd15, 4'd15, "R1 R3 hit last entry");
    do_lookup(32'hDEAD_0001, 1'b0, 4'd0, 4'd0, "R6 victim 0");
    do_lookup(32'h1000_0000, 1'b1, 4'd0, 4'd0, "R3 hit entry 0");
    do_lookup(32'hDEAD_0002, 1'b0, 4'd3, 4'd0, "R6 victim after hit");
    do_lookup(32'hDEAD_0003, 1'b0, 4'd3, 4'd0, "R6 miss keeps order");

    // R7, R8: clear invalidates and resets order
    do_clear();
    do_lookup(32'h1000_0001, 1'b0, 4'd0, 4'd0, "R7 R8 cleared miss");
    do_write(4'd0, 32'hAAAA_0000, 4'd7);
    do_lookup(32'hBBBB_0000, 1'b0, 4'd1, 4'd0, "R7 order restarts");

    // R9: write wins over lookup; lookup dropped
    wr_valid_i = 1'b1; wr_idx_i = 4'd1; wr_tag_i = 32'hCCCC_0001; wr_state_i = 4'd9;
    lkp_valid_i = 1'b1; lkp_key_i = 32'hAAAA_0000;
    @(negedge clk_i);
    idle_inputs();
    check("R9 lookup dropped on write", {9'd0, res_valid_o}, 10'd0);
    do_lookup(32'hCCCC_0001, 1'b1, 4'd1, 4'd9, "R9 write took effect");

    // R9: clear wins over write
    clr_i = 1'b1; wr_valid_i = 1'b1; wr_idx_i = 4'd5; wr_tag_i = 32'hEEEE_0005; wr_state_i = 4'd3;
    @(negedge clk_i);
    idle_inputs();
    do_lookup(32'hEEEE_0005, 1'b0, 4'd0, 4'd0, "R9 write dropped on clear");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule